// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of `W`-bit words (default 9 bits, depth `D` = 256) whose write side and read side run from independent clocks. Pointers cross between the clock domains in Gray code through two-stage synchronizers. Each side computes the word count it sees and drives registered status flags from it.

All four flags are active-low. `empty_n` and `aempty_n` belong to the read clock, and `full_n` and `afull_n` belong to the write clock. A write needs both write enables asserted, and a read needs both read enables asserted. The almost-empty offset `n` and the almost-full offset `m` both reset to 7. They can be reprogrammed when the part comes out of reset in load mode. In that mode the second write-enable pin becomes a load strobe, and the offsets are written and read back one byte at a time.

Reset is a single active-high input. Each clock domain samples it synchronously, so it must be held for several cycles of both clocks. The offsets are quasi-static: load them while no traffic is flowing.

Top module: `fifo_dc_progflag`

## Requirements
- R1: While `rst` is high and after its release: `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, `rd_data`=0, and both offsets are 7.
- R2: Words come out on `rd_data` in write order. `rd_data` changes one read-clock edge after an accepted read.
- R3: `full_n` goes low when the count reaches `D`. While it is low, write attempts change neither the stored data nor the count.
- R4: `empty_n` is low exactly when the count is 0. A read attempt while it is low leaves `rd_data` and the count unchanged.
- R5: `aempty_n` is low for counts 0 to `n` and high for counts `n`+1 and above.
- R6: `afull_n` is low for counts of `D`-`m` or more and high for counts up to `D`-`m`-1.
- R7: In normal mode a word is written only when `wr_en1_n`=0 and `wr_en2_ld_n`=0 at a write-clock edge.
- R8: A read occurs only when `rd_en1_n`=0 and `rd_en2_n`=0. Tying `rd_en2_n` low leaves `rd_en1_n` alone in control.
- R9: If `wr_en2_ld_n` is 0 while `rst` is high, load mode is selected until the next reset. In load mode:
  - A write-clock edge with `wr_en1_n`=0 and `wr_en2_ld_n`=0 writes `wr_data[7:0]` into the next offset byte, and no FIFO write takes place.
  - The bytes are written in the order n low, n high, m low, m high, then the order wraps.
  - Each offset is masked to `D`-1.
  - `wr_en1_n`=0 with `wr_en2_ld_n`=1 is a FIFO write.
- R10: In load mode, a read-clock edge with `rd_en1_n`=0 and `wr_en2_ld_n`=0 puts the next offset byte on `rd_data` (zero-extended), in the same rotating order. No FIFO read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Active-high reset, synchronous in each domain |
| wr_en1_n | input | 1 | First write enable, active-low |
| wr_en2_ld_n | input | 1 | Second write enable, or offset load strobe in load mode, active-low |
| wr_data | input | W | Write data (low byte carries offset values) |
| rd_en1_n | input | 1 | First read enable, active-low |
| rd_en2_n | input | 1 | Second read enable, active-low |
| rd_data | output | W | Registered read data or offset readback byte |
| empty_n | output | 1 | Empty flag, active-low, read clock |
| full_n | output | 1 | Full flag, active-low, write clock |
| aempty_n | output | 1 | Almost-empty flag, active-low, read clock |
| afull_n | output | 1 | Almost-full flag, active-low, write clock |

## Verification
The bench fills the buffer to exactly `D` and pushes extra writes against the full flag. A design that let those writes through would overwrite the oldest word, and the readback of all 256 words would then fail.

It drains past empty and checks that `rd_data` holds its last value. It places the counts exactly at `n`/`n`+1 and at `D`-`m`-1/`D`-`m` for several programmed offsets. An off-by-one comparison would flip a flag one word early or late.

Load-mode tests write five offset bytes, to exercise the rotation's wrap, and write a high byte beyond `D`-1. Rotating the bytes in the wrong order or failing to mask would show up as wrong thresholds or wrong readback bytes.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;
  typedef enum logic [1:0] {
    OSEL_E_LO = 2'd0,
    OSEL_E_HI = 2'd1,
    OSEL_F_LO = 2'd2,
    OSEL_F_HI = 2'd3
  } ofs_sel_e;

  typedef logic [15:0] ofs_t;

  localparam ofs_t OFS_RESET = 16'd7;
endpackage

// File: rtl/fdc_ram.sv
module fdc_ram #(
  parameter int W  = 9,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fdc_ptr_sync.sv
module fdc_ptr_sync #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) bin_out[i] = ^(stage2 >> i);
  end
endmodule

// File: rtl/fdc_offsets.sv
module fdc_offsets
  import fifo_dc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          ld_wr,
  input  logic [7:0]    ld_byte,
  input  logic          ld_rd,
  output logic [AW-1:0] ofs_empty,
  output logic [AW-1:0] ofs_full,
  output logic [7:0]    rb_byte
);
  localparam ofs_t MASK = ofs_t'((1 << AW) - 1);

  ofs_t     e_q, f_q;
  ofs_sel_e wsel_q, rsel_q;

  always_ff @(posedge wclk) begin
    if (rst) begin
      e_q    <= OFS_RESET & MASK;
      f_q    <= OFS_RESET & MASK;
      wsel_q <= OSEL_E_LO;
    end else if (ld_wr) begin
      unique case (wsel_q)
        OSEL_E_LO: e_q <= {e_q[15:8], ld_byte} & MASK;
        OSEL_E_HI: e_q <= {ld_byte, e_q[7:0]} & MASK;
        OSEL_F_LO: f_q <= {f_q[15:8], ld_byte} & MASK;
        OSEL_F_HI: f_q <= {ld_byte, f_q[7:0]} & MASK;
        default:   ;
      endcase
      wsel_q <= ofs_sel_e'(wsel_q + 2'd1);
    end
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rb_byte <= '0;
      rsel_q  <= OSEL_E_LO;
    end else if (ld_rd) begin
      unique case (rsel_q)
        OSEL_E_LO: rb_byte <= e_q[7:0];
        OSEL_E_HI: rb_byte <= e_q[15:8];
        OSEL_F_LO: rb_byte <= f_q[7:0];
        OSEL_F_HI: rb_byte <= f_q[15:8];
        default:   ;
      endcase
      rsel_q <= ofs_sel_e'(rsel_q + 2'd1);
    end
  end

  assign ofs_empty = e_q[AW-1:0];
  assign ofs_full  = f_q[AW-1:0];
endmodule

// File: rtl/fifo_dc_progflag.sv
module fifo_dc_progflag #(
  parameter int W = 9,
  parameter int D = 256
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst,
  input  logic         wr_en1_n,
  input  logic         wr_en2_ld_n,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en1_n,
  input  logic         rd_en2_n,
  output logic [W-1:0] rd_data,
  output logic         empty_n,
  output logic         full_n,
  output logic         aempty_n,
  output logic         afull_n
);
  localparam int AW = $clog2(D);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_C = PW'(D);

  // ---------------- write domain ----------------
  logic          lm_w;
  logic [PW-1:0] wptr_bin, wptr_gray, wptr_nx, rptr_sync;
  logic [PW-1:0] wcnt_nx, afull_lim;
  logic          wr_req, wr_do, ld_wr;
  logic [AW-1:0] ofs_e, ofs_f;

  assign ld_wr  = lm_w && !wr_en1_n && !wr_en2_ld_n;
  assign wr_req = !wr_en1_n && (lm_w ? wr_en2_ld_n : !wr_en2_ld_n);
  assign wr_do  = wr_req && full_n;
  assign wptr_nx   = wptr_bin + PW'(wr_do);
  assign wcnt_nx   = wptr_nx - rptr_sync;
  assign afull_lim = DEPTH_C - {1'b0, ofs_f};

  always_ff @(posedge wclk) begin
    if (rst) begin
      lm_w      <= !wr_en2_ld_n;
      wptr_bin  <= '0;
      wptr_gray <= '0;
      full_n    <= 1'b1;
      afull_n   <= 1'b1;
    end else begin
      wptr_bin  <= wptr_nx;
      wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
      full_n    <= (wcnt_nx != DEPTH_C);
      afull_n   <= (wcnt_nx < afull_lim);
    end
  end

  // ---------------- read domain ----------------
  logic          lm_r;
  logic [PW-1:0] rptr_bin, rptr_gray, rptr_nx, wptr_sync, rcnt_nx;
  logic          rd_req, rd_do, ld_rd, rd_src_q;
  logic [W-1:0]  mem_q;
  logic [7:0]    rb_byte;

  assign ld_rd   = lm_r && !wr_en2_ld_n && !rd_en1_n;
  assign rd_req  = !rd_en1_n && !rd_en2_n && !ld_rd;
  assign rd_do   = rd_req && empty_n;
  assign rptr_nx = rptr_bin + PW'(rd_do);
  assign rcnt_nx = wptr_sync - rptr_nx;

  always_ff @(posedge rclk) begin
    if (rst) begin
      lm_r      <= !wr_en2_ld_n;
      rptr_bin  <= '0;
      rptr_gray <= '0;
      empty_n   <= 1'b0;
      aempty_n  <= 1'b0;
      rd_src_q  <= 1'b0;
    end else begin
      rptr_bin  <= rptr_nx;
      rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
      empty_n   <= (rcnt_nx != '0);
      aempty_n  <= (rcnt_nx > {1'b0, ofs_e});
      if (ld_rd)      rd_src_q <= 1'b1;
      else if (rd_do) rd_src_q <= 1'b0;
    end
  end

  assign rd_data = rd_src_q ? W'(rb_byte) : mem_q;

  // ---------------- submodules ----------------
  fdc_ram #(.W(W), .AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (wr_do),
    .waddr (wptr_bin[AW-1:0]),
    .wdata (wr_data),
    .rclk  (rclk),
    .rst   (rst),
    .re    (rd_do),
    .raddr (rptr_bin[AW-1:0]),
    .rdata (mem_q)
  );

  fdc_ptr_sync #(.PW(PW)) u_sync_r2w (
    .clk     (wclk),
    .rst     (rst),
    .gray_in (rptr_gray),
    .bin_out (rptr_sync)
  );

  fdc_ptr_sync #(.PW(PW)) u_sync_w2r (
    .clk     (rclk),
    .rst     (rst),
    .gray_in (wptr_gray),
    .bin_out (wptr_sync)
  );

  fdc_offsets #(.AW(AW)) u_ofs (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst       (rst),
    .ld_wr     (ld_wr),
    .ld_byte   (wr_data[7:0]),
    .ld_rd     (ld_rd),
    .ofs_empty (ofs_e),
    .ofs_full  (ofs_f),
    .rb_byte   (rb_byte)
  );

  initial begin
    if ((1 << AW) != D) $error("D must be a power of two");
    if (W < 8) $error("W must be at least 8");
  end
endmodule

// File: rtl/fifo_dc_progflag_chk.sv
module fifo_dc_progflag_chk #(
  parameter int PW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wr_en1_n,
  input logic          wr_en2_ld_n,
  input logic          rd_en1_n,
  input logic          empty_n,
  input logic          full_n,
  input logic          aempty_n,
  input logic          afull_n,
  input logic          lm_w,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin
);
  // R1: flags leave reset in their documented state
  a_r1_wr_flags_reset: assert property (@(posedge wclk) disable iff (rst)
    $fell(rst) |-> (full_n && afull_n));
  a_r1_rd_flags_reset: assert property (@(posedge rclk) disable iff (rst)
    $fell(rst) |-> (!empty_n && !aempty_n));

  // R3: no pointer motion while full
  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (rst)
    (!full_n && !wr_en1_n) |=> (wptr_bin == $past(wptr_bin)));

  // R4: no pointer motion while empty
  a_r4_no_underflow: assert property (@(posedge rclk) disable iff (rst)
    (!empty_n && !rd_en1_n) |=> (rptr_bin == $past(rptr_bin)));

  // R5: empty implies almost-empty
  a_r5_empty_in_aempty: assert property (@(posedge rclk) disable iff (rst)
    !empty_n |-> !aempty_n);

  // R6: full implies almost-full
  a_r6_full_in_afull: assert property (@(posedge wclk) disable iff (rst)
    !full_n |-> !afull_n);

  // R9: offset load cycles never write the FIFO
  a_r9_load_no_write: assert property (@(posedge wclk) disable iff (rst)
    (lm_w && !wr_en1_n && !wr_en2_ld_n) |=> (wptr_bin == $past(wptr_bin)));
endmodule

bind fifo_dc_progflag fifo_dc_progflag_chk #(.PW(PW)) u_chk (
  .wclk        (wclk),
  .rclk        (rclk),
  .rst         (rst),
  .wr_en1_n    (wr_en1_n),
  .wr_en2_ld_n (wr_en2_ld_n),
  .rd_en1_n    (rd_en1_n),
  .empty_n     (empty_n),
  .full_n      (full_n),
  .aempty_n    (aempty_n),
  .afull_n     (afull_n),
  .lm_w        (lm_w),
  .wptr_bin    (wptr_bin),
  .rptr_bin    (rptr_bin)
);

// File: tb/fifo_dc_progflag_bench.sv
`timescale 1ns/1ps
module fifo_dc_progflag_bench;
  localparam int W = 9;
  localparam int D = 256;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic wr_en1_n = 1'b1, wr_en2_ld_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic empty_n, full_n, aempty_n, afull_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 wclk = ~wclk;   // 250 MHz write clock
  always #3 rclk = ~rclk;   // read clock on a different period

  fifo_dc_progflag #(.W(W), .D(D)) u_fifo_dc_progflag (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .wr_en1_n(wr_en1_n), .wr_en2_ld_n(wr_en2_ld_n), .wr_data(wr_data),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .rd_data(rd_data),
    .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  // offset vectors: n_lo, n_hi, m_lo, m_hi, expected n, expected m
  localparam int NV = 3;
  localparam int VEC [NV][6] = '{
    '{3,  0, 5,  0, 3,  5},
    '{0,  1, 1,  2, 0,  1},
    '{20, 0, 30, 0, 20, 30}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic do_reset(input bit load);
    @(negedge wclk);
    rst = 1'b1; wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b0;
    wr_en2_ld_n = load ? 1'b0 : 1'b1;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    rst = 1'b0; wr_en2_ld_n = 1'b1;
    repeat (3) @(negedge rclk);
  endtask

  task automatic wr(input int d, input logic en2);
    @(negedge wclk);
    wr_en1_n = 1'b0; wr_en2_ld_n = en2; wr_data = W'(d);
    @(negedge wclk);
    wr_en1_n = 1'b1; wr_en2_ld_n = 1'b1;
  endtask

  task automatic rd(input logic en2, output int v);
    @(negedge rclk);
    rd_en1_n = 1'b0; rd_en2_n = en2;
    @(negedge rclk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic rb(output int v);
    @(negedge rclk);
    rd_en1_n = 1'b0; wr_en2_ld_n = 1'b0;
    @(negedge rclk);
    rd_en1_n = 1'b1; wr_en2_ld_n = 1'b1;
    v = int'(rd_data);
  endtask

  function automatic int pat(input int i);
    return ((i * 37) ^ 9'h155) & 9'h1ff;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge wclk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int v;
    // ---- table walk: programmed thresholds (R5, R6, R9, R10) ----
    for (int t = 0; t < NV; t++) begin
      int n, m;
      n = VEC[t][4]; m = VEC[t][5];
      do_reset(1'b1);
      for (int b = 0; b < 4; b++) wr(VEC[t][b], 1'b0);
      settle();
      chk(empty_n == 1'b0, "R9 load writes no FIFO data", empty_n, 0);
      rb(v); chk(v == (n & 255), "R10 readback n low", v, n & 255);
      rb(v); chk(v == (n >> 8),  "R10 readback n high", v, n >> 8);
      rb(v); chk(v == (m & 255), "R10 readback m low", v, m & 255);
      rb(v); chk(v == (m >> 8),  "R10 readback m high", v, m >> 8);
      for (int k = 0; k < n; k++) wr(k, 1'b1);
      settle();
      chk(aempty_n == 1'b0, "R5 count n almost-empty low", aempty_n, 0);
      wr(n, 1'b1);
      settle();
      chk(aempty_n == 1'b1, "R5 count n+1 almost-empty high", aempty_n, 1);
      for (int k = n + 1; k < D - m - 1; k++) wr(k, 1'b1);
      settle();
      chk(afull_n == 1'b1, "R6 count D-m-1 almost-full high", afull_n, 1);
      wr(D - m - 1, 1'b1);
      settle();
      chk(afull_n == 1'b0, "R6 count D-m almost-full low", afull_n, 0);
      chk(full_n == 1'b1, "R3 not full below D", full_n, 1);
      rd(1'b0, v);
      chk(v == 0, "R2 first word in load mode", v, 0);
    end

    // ---- load-mode byte rotation wrap and masking (R9, R10) ----
    do_reset(1'b1);
    wr(10, 1'b0); wr(255, 1'b0); wr(20, 1'b0); wr(0, 1'b0); wr(4, 1'b0);
    settle();
    rb(v); chk(v == 4,  "R9 wrap rewrites n low", v, 4);
    rb(v); chk(v == 0,  "R9 high byte masked to D-1", v, 0);
    rb(v); chk(v == 20, "R10 readback m low", v, 20);
    rb(v); chk(v == 0,  "R10 readback m high", v, 0);
    rb(v); chk(v == 4,  "R10 readback order wraps", v, 4);

    // ---- reset defaults in load mode (R1) ----
    do_reset(1'b1);
    rb(v); chk(v == 7, "R1 default n", v, 7);
    rb(v); rb(v); chk(v == 7, "R1 default m", v, 7);

    // ---- normal mode reset state (R1) ----
    do_reset(1'b0);
    chk(empty_n == 1'b0 && aempty_n == 1'b0, "R1 empty flags after reset",
        {empty_n, aempty_n}, 0);
    chk(full_n == 1'b1 && afull_n == 1'b1, "R1 full flags after reset",
        {full_n, afull_n}, 3);
    chk(rd_data == '0, "R1 rd_data after reset", rd_data, 0);

    // ---- R7: second enable required ----
    wr(5, 1'b1);
    settle();
    chk(empty_n == 1'b0, "R7 write with en2 high ignored", empty_n, 0);
    rd(1'b0, v);
    chk(v == 0, "R4 read while empty keeps rd_data", v, 0);

    // ---- default threshold 7 (R1, R5) ----
    for (int k = 0; k < 7; k++) wr(pat(k), 1'b0);
    settle();
    chk(aempty_n == 1'b0 && empty_n == 1'b1, "R1 default n=7 at count 7",
        {empty_n, aempty_n}, 2);
    wr(pat(7), 1'b0);
    settle();
    chk(aempty_n == 1'b1, "R1 default n=7 at count 8", aempty_n, 1);

    // ---- fill to D (R3, R6 default m=7) ----
    for (int k = 8; k < D - 8; k++) wr(pat(k), 1'b0);
    settle();
    chk(afull_n == 1'b1, "R6 default count D-8 almost-full high", afull_n, 1);
    wr(pat(D - 8), 1'b0);
    settle();
    chk(afull_n == 1'b0, "R6 default count D-7 almost-full low", afull_n, 0);
    for (int k = D - 7; k < D; k++) wr(pat(k), 1'b0);
    settle();
    chk(full_n == 1'b0, "R3 full at count D", full_n, 0);
    for (int k = 0; k < 3; k++) wr(9'h0aa + k, 1'b0);
    settle();

    // ---- R8: blocked read with en2 high ----
    rd(1'b1, v);
    chk(v == 0, "R8 read with en2 high ignored", v, 0);

    // ---- drain and compare order (R2, R3) ----
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < D; k++) begin
        rd(1'b0, v);
        if (v != pat(k) && bad == 0) begin
          chk(1'b0, "R2 order after full (R3 overflow check)", v, pat(k));
          bad = 1;
        end
      end
      if (bad == 0) chk(1'b1, "R2 order", 0, 0);
    end
    settle();
    chk(empty_n == 1'b0, "R4 empty after drain", empty_n, 0);
    chk(full_n == 1'b1, "R3 full released after drain", full_n, 1);
    rd(1'b0, v);
    chk(v == pat(D - 1), "R4 read past empty holds data", v, pat(D - 1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule